// File: doc/BRIEF.md
# Two-Level Interrupt Mask Controller

This block gathers level-sensitive interrupt lines and delivers each one to a set of processor cores through two gates in series. The first gate is a single enable per source, shared by all cores. The second gate is a mask per core and per source. Between them sits a per-source routing word that names the cores whose IRQ or FIQ line the source may drive. Software programs both gates by writing a source number to an index register, never a bitmask. A core acknowledge register tells the reading core which source to service first.

The register bus is plain: one address, write data, a write strobe, a read strobe and a core number. The core number tells the block which core is making the access, so the mask window and the acknowledge register always act on that core's private copy. Sources 0 and 1 stand for internal aggregate groups. Software cannot enable, disable or route them, but each core can still mask them. Sources numbered up to a parameter limit (28 by default) are private to each core. For these, IRQ delivery depends only on the core's own mask, and the routing word's IRQ bits are not used.

Top module: `dual_gate_intc`

## Requirements
- R1: After reset, every software-controlled enable is clear, every core mask bit is set, every routing word reads 0, no IRQ or FIQ output is high, and the acknowledge register reads 1023 for every core.
- R2: Offset 0x000 reads the number of implemented sources in bits [11:2], with all other bits 0. Any offset with no register reads 0.
- R3: Writing a source number (write data bits [9:0]) to offset 0x030 sets that source's enable. Writing it to offset 0x034 clears that source's enable. No other source is affected.
- R4: Enable set and clear writes that name source 0, source 1, or a number not below the source count have no effect. Sources 0 and 1 always pass the enable gate.
- R5: Writing a source number to offset 0x048 sets that source's mask bit for the accessing core (bus_core). Writing it to offset 0x04C clears that mask bit. The masks of other cores do not change.
- R6: The routing word of source s is at offset 0x100 + 4*s. Bit n is the IRQ route to core n and bit 8+n is the FIQ route to core n. All other bits read 0. Writes to the words of sources 0 and 1 are ignored, and those words read 0.
- R7: A source above the private limit drives core_irq[n] only when it is asserted, enabled, unmasked for core n, and has IRQ route bit n set.
- R8: A source at or below the private limit drives core_irq[n] when it is asserted, enabled and unmasked for core n, whatever its IRQ route bits are.
- R9: Any source drives core_fiq[n] when it is asserted, enabled, unmasked for core n, and has FIQ route bit n set.
- R10: Reading offset 0x044 returns, in bits [9:0], the lowest-numbered source that qualifies for IRQ delivery to the accessing core, or 1023 when none qualifies. Bits [31:10] read 0.
- R11: A write changes state at the clock edge that samples it. core_irq and core_fiq are registered, so they follow the state and the inputs one edge later. Read data appears in the cycle after the read strobe and shows the state from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_core | input | CORE_W | Number of the core making the access |
| bus_rdata | output | 32 | Read data, registered |
| src_lvl | input | NUM_SRC | Level interrupt inputs |
| core_irq | output | NUM_CORE | IRQ line for each core |
| core_fiq | output | NUM_CORE | FIQ line for each core |

## Verification
Two things can land on the same clock edge: a change on the source inputs and a register write that alters the gates for that same source. The bench raises a source and masks it for a core in one cycle. The core's IRQ line must then pulse for exactly one cycle, because the output register still holds the mask from before the write, and must drop on the next edge. The bench also reads and writes one routing word in the same cycle. It expects the old contents first and the new contents on the following read.

// File: rtl/dgi_pkg.sv
package dgi_pkg;

  // Register offsets; software decodes these, so they are fixed
  localparam int unsigned OFS_INFO  = 32'h000;
  localparam int unsigned OFS_GSET  = 32'h030;
  localparam int unsigned OFS_GCLR  = 32'h034;
  localparam int unsigned OFS_ACK   = 32'h044;
  localparam int unsigned OFS_MSET  = 32'h048;
  localparam int unsigned OFS_MCLR  = 32'h04C;
  localparam int unsigned OFS_ROUTE = 32'h100;

  localparam int unsigned ACK_NONE  = 1023;
  localparam int unsigned FIQ_SHIFT = 8;
  localparam int unsigned N_INTERNAL = 2;

  typedef struct packed {
    logic gset;
    logic gclr;
    logic mset;
    logic mclr;
    logic route_wr;
  } wr_ops_t;

  // True when addr falls on a routing word of an implemented source
  function automatic logic route_hit(input int unsigned addr, input int unsigned nsrc);
    return (addr >= OFS_ROUTE) && ((addr & 32'd3) == 32'd0) &&
           (((addr - OFS_ROUTE) >> 2) < nsrc);
  endfunction

  // Source number addressed by a routing-word offset
  function automatic int unsigned route_slot(input int unsigned addr);
    return (addr - OFS_ROUTE) >> 2;
  endfunction

endpackage

// File: rtl/dgi_state.sv
module dgi_state
  import dgi_pkg::*;
#(
  parameter int NUM_SRC  = 40,
  parameter int NUM_CORE = 4,
  parameter int SRC_W    = 6,
  parameter int CORE_W   = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  wr_ops_t                            ops,
  input  logic [SRC_W-1:0]                   op_idx,
  input  logic [CORE_W-1:0]                  op_core,
  input  logic [SRC_W-1:0]                   rt_idx,
  input  logic [NUM_CORE-1:0]                rt_irq_in,
  input  logic [NUM_CORE-1:0]                rt_fiq_in,
  output logic [NUM_SRC-1:0]                 gen_eff,
  output logic [NUM_CORE-1:0][NUM_SRC-1:0]   mask_q,
  output logic [NUM_SRC-1:0][NUM_CORE-1:0]   rt_irq,
  output logic [NUM_SRC-1:0][NUM_CORE-1:0]   rt_fiq
);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s < N_INTERNAL) begin : g_internal
      assign gen_eff[s] = 1'b1;
      assign rt_irq[s]  = '0;
      assign rt_fiq[s]  = '0;
    end else begin : g_dev
      logic                en_q;
      logic [NUM_CORE-1:0] ri_q;
      logic [NUM_CORE-1:0] rf_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q <= 1'b0;
          ri_q <= '0;
          rf_q <= '0;
        end else begin
          if (ops.gset && op_idx == SRC_W'(s))
            en_q <= 1'b1;
          else if (ops.gclr && op_idx == SRC_W'(s))
            en_q <= 1'b0;
          if (ops.route_wr && rt_idx == SRC_W'(s)) begin
            ri_q <= rt_irq_in;
            rf_q <= rt_fiq_in;
          end
        end
      end
      assign gen_eff[s] = en_q;
      assign rt_irq[s]  = ri_q;
      assign rt_fiq[s]  = rf_q;
    end
  end

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    logic [NUM_SRC-1:0] m_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q <= '1;
      end else if (op_core == CORE_W'(c)) begin
        if (ops.mset)
          m_q[op_idx] <= 1'b1;
        else if (ops.mclr)
          m_q[op_idx] <= 1'b0;
      end
    end
    assign mask_q[c] = m_q;
  end

endmodule

// File: rtl/dgi_deliver.sv
module dgi_deliver
  import dgi_pkg::*;
#(
  parameter int NUM_SRC   = 40,
  parameter int NUM_CORE  = 4,
  parameter int PRIV_LAST = 28
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_SRC-1:0]                 src_lvl,
  input  logic [NUM_SRC-1:0]                 gen_eff,
  input  logic [NUM_CORE-1:0][NUM_SRC-1:0]   mask_q,
  input  logic [NUM_SRC-1:0][NUM_CORE-1:0]   rt_irq,
  input  logic [NUM_SRC-1:0][NUM_CORE-1:0]   rt_fiq,
  output logic [NUM_CORE-1:0]                core_irq,
  output logic [NUM_CORE-1:0]                core_fiq,
  output logic [NUM_CORE-1:0][9:0]           ack_num
);

  // Lowest set position, or the idle code when the vector is empty
  function automatic logic [9:0] first_set(input logic [NUM_SRC-1:0] v);
    logic [9:0] r;
    r = 10'(ACK_NONE);
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (v[i]) r = 10'(i);
    return r;
  endfunction

  logic [NUM_SRC-1:0] live;
  assign live = src_lvl & gen_eff;

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    logic [NUM_SRC-1:0] elig_irq;
    logic [NUM_SRC-1:0] elig_fiq;
    logic               irq_q;
    logic               fiq_q;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (s <= PRIV_LAST) begin : g_priv
        assign elig_irq[s] = live[s] & ~mask_q[c][s];
      end else begin : g_shared
        assign elig_irq[s] = live[s] & ~mask_q[c][s] & rt_irq[s][c];
      end
      assign elig_fiq[s] = live[s] & ~mask_q[c][s] & rt_fiq[s][c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_q <= 1'b0;
        fiq_q <= 1'b0;
      end else begin
        irq_q <= |elig_irq;
        fiq_q <= |elig_fiq;
      end
    end

    assign core_irq[c] = irq_q;
    assign core_fiq[c] = fiq_q;
    assign ack_num[c]  = first_set(elig_irq);
  end

endmodule

// File: rtl/dual_gate_intc.sv
module dual_gate_intc
  import dgi_pkg::*;
#(
  parameter int NUM_SRC   = 40,
  parameter int NUM_CORE  = 4,
  parameter int PRIV_LAST = 28,
  parameter int ADDR_W    = 12,
  localparam int CORE_W   = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [CORE_W-1:0]   bus_core,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_SRC-1:0]  src_lvl,
  output logic [NUM_CORE-1:0] core_irq,
  output logic [NUM_CORE-1:0] core_fiq
);

  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  // Decode of the write index and of routing-word addresses
  logic [31:0]       wr_num;
  logic              idx_ok;
  logic              idx_dev;
  logic [SRC_W-1:0]  op_idx;
  logic              rt_hit;
  logic [SRC_W-1:0]  rt_idx;
  wr_ops_t           ops;
  logic              unused_wdata_hi;

  assign wr_num  = {22'd0, bus_wdata[9:0]};
  assign idx_ok  = wr_num < 32'(NUM_SRC);
  assign idx_dev = idx_ok && (wr_num >= 32'(N_INTERNAL));
  assign op_idx  = SRC_W'(wr_num);
  assign rt_hit  = route_hit(32'(bus_addr), NUM_SRC);
  assign rt_idx  = SRC_W'(route_slot(32'(bus_addr)));
  assign unused_wdata_hi = ^bus_wdata[31:FIQ_SHIFT+NUM_CORE];

  assign ops.gset     = bus_wr && (bus_addr == ADDR_W'(OFS_GSET)) && idx_dev;
  assign ops.gclr     = bus_wr && (bus_addr == ADDR_W'(OFS_GCLR)) && idx_dev;
  assign ops.mset     = bus_wr && (bus_addr == ADDR_W'(OFS_MSET)) && idx_ok;
  assign ops.mclr     = bus_wr && (bus_addr == ADDR_W'(OFS_MCLR)) && idx_ok;
  assign ops.route_wr = bus_wr && rt_hit && (rt_idx >= SRC_W'(N_INTERNAL));

  // Named internal state for the checker
  logic [NUM_SRC-1:0]               gen_eff;
  logic [NUM_CORE-1:0][NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0][NUM_CORE-1:0] rt_irq;
  logic [NUM_SRC-1:0][NUM_CORE-1:0] rt_fiq;
  logic [NUM_CORE-1:0][9:0]         ack_num;

  dgi_state #(
    .NUM_SRC  (NUM_SRC),
    .NUM_CORE (NUM_CORE),
    .SRC_W    (SRC_W),
    .CORE_W   (CORE_W)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .ops       (ops),
    .op_idx    (op_idx),
    .op_core   (bus_core),
    .rt_idx    (rt_idx),
    .rt_irq_in (bus_wdata[NUM_CORE-1:0]),
    .rt_fiq_in (bus_wdata[FIQ_SHIFT +: NUM_CORE]),
    .gen_eff   (gen_eff),
    .mask_q    (mask_q),
    .rt_irq    (rt_irq),
    .rt_fiq    (rt_fiq)
  );

  dgi_deliver #(
    .NUM_SRC   (NUM_SRC),
    .NUM_CORE  (NUM_CORE),
    .PRIV_LAST (PRIV_LAST)
  ) u_deliver (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_lvl  (src_lvl),
    .gen_eff  (gen_eff),
    .mask_q   (mask_q),
    .rt_irq   (rt_irq),
    .rt_fiq   (rt_fiq),
    .core_irq (core_irq),
    .core_fiq (core_fiq),
    .ack_num  (ack_num)
  );

  // Read mux, sampled from pre-write state
  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (bus_addr == ADDR_W'(OFS_INFO)) begin
      rd_val = 32'(NUM_SRC) << 2;
    end else if (bus_addr == ADDR_W'(OFS_ACK)) begin
      rd_val[9:0] = ack_num[bus_core];
    end else if (rt_hit) begin
      rd_val[NUM_CORE-1:0]          = rt_irq[rt_idx];
      rd_val[FIQ_SHIFT +: NUM_CORE] = rt_fiq[rt_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else
      bus_rdata <= bus_rd ? rd_val : '0;
  end

endmodule

// File: rtl/dgi_checker.sv
module dgi_checker
  import dgi_pkg::*;
#(
  parameter int NUM_SRC  = 40,
  parameter int NUM_CORE = 4,
  parameter int ADDR_W   = 12,
  parameter int CORE_W   = 2
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [ADDR_W-1:0]                  bus_addr,
  input logic [31:0]                        bus_wdata,
  input logic                               bus_wr,
  input logic                               bus_rd,
  input logic [CORE_W-1:0]                  bus_core,
  input logic [31:0]                        bus_rdata,
  input logic [NUM_SRC-1:0]                 src_lvl,
  input logic [NUM_CORE-1:0]                core_irq,
  input logic [NUM_CORE-1:0]                core_fiq,
  input logic [NUM_SRC-1:0]                 gen_eff,
  input logic [NUM_CORE-1:0][NUM_SRC-1:0]   mask_q
);

  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic dev_idx;
  logic any_idx;
  assign any_idx = {22'd0, bus_wdata[9:0]} < 32'(NUM_SRC);
  assign dev_idx = any_idx && ({22'd0, bus_wdata[9:0]} >= 32'(N_INTERNAL));

  // R3
  gset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_GSET) && dev_idx)
      |=> gen_eff[$past(bus_wdata[SRC_W-1:0])]);

  // R3
  gclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_GCLR) && dev_idx)
      |=> !gen_eff[$past(bus_wdata[SRC_W-1:0])]);

  // R5
  mset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_MSET) && any_idx)
      |=> mask_q[$past(bus_core)][$past(bus_wdata[SRC_W-1:0])]);

  // R7
  irq_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_irq != '0) |-> ($past(src_lvl) != '0));

  // R9
  fiq_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_fiq != '0) |-> ($past(src_lvl) != '0));

  // R10
  ack_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(OFS_ACK))
      |=> (bus_rdata[31:10] == '0) &&
          ((bus_rdata[9:0] == 10'(ACK_NONE)) || ({22'd0, bus_rdata[9:0]} < 32'(NUM_SRC))));

endmodule

bind dual_gate_intc dgi_checker #(
  .NUM_SRC  (NUM_SRC),
  .NUM_CORE (NUM_CORE),
  .ADDR_W   (ADDR_W),
  .CORE_W   (CORE_W)
) u_dgi_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_core  (bus_core),
  .bus_rdata (bus_rdata),
  .src_lvl   (src_lvl),
  .core_irq  (core_irq),
  .core_fiq  (core_fiq),
  .gen_eff   (gen_eff),
  .mask_q    (mask_q)
);

// File: tb/dual_gate_intc_bench.sv
`timescale 1ns/1ps
module dual_gate_intc_bench;

  localparam int NSRC  = 40;
  localparam int NCORE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_core = '0;
  logic [31:0] bus_rdata;
  logic [NSRC-1:0]  src_lvl = '0;
  logic [NCORE-1:0] core_irq;
  logic [NCORE-1:0] core_fiq;

  always #2 clk = ~clk;

  dual_gate_intc u_dual_gate_intc (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_core  (bus_core),
    .bus_rdata (bus_rdata),
    .src_lvl   (src_lvl),
    .core_irq  (core_irq),
    .core_fiq  (core_fiq)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [1:0] c);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_core = c; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [1:0] c, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_core = c; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic out_sample(output logic [31:0] o);
    @(posedge clk);
    @(negedge clk);
    o = {24'd0, core_fiq, core_irq};
  endtask

  // Vector kinds: write, read-and-compare, set sources, compare outputs {fiq,irq}
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_SRC = 2'd2, K_OUT = 2'd3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  core;
    logic [11:0] addr;
    logic [63:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{K_RD,  2'd0, 12'h000, 64'd0,            32'h0A0, 8'd2},  // R2 source count
    '{K_RD,  2'd0, 12'h044, 64'd0,            32'd1023, 8'd1}, // R1 idle ack
    '{K_SRC, 2'd0, 12'h000, 64'hFF_FFFF_FFFF, 32'd0,   8'd1},  // R1
    '{K_OUT, 2'd0, 12'h000, 64'd0,            32'h00,  8'd1},  // R1 all masked
    '{K_RD,  2'd0, 12'h18C, 64'd0,            32'd0,   8'd1},  // R1 route zero
    '{K_SRC, 2'd0, 12'h000, 64'h8_0000_0000,  32'd0,   8'd7},  // R7 source 35
    '{K_WR,  2'd0, 12'h030, 64'd35,           32'd0,   8'd3},  // R3 enable 35
    '{K_WR,  2'd2, 12'h04C, 64'd35,           32'd0,   8'd5},  // R5 unmask core2
    '{K_OUT, 2'd0, 12'h000, 64'd0,            32'h00,  8'd7},  // R7 no route yet
    '{K_WR,  2'd0, 12'h18C, 64'h4,            32'd0,   8'd6},  // R6 route irq core2
    '{K_OUT, 2'd0, 12'h000, 64'd0,            32'h04,  8'd7},  // R7
    '{K_RD,  2'd2, 12'h044, 64'd0,            32'd35,  8'd10}, // R10
    '{K_RD,  2'd1, 12'h044, 64'd0,            32'd1023, 8'd5}, // R5 core1 still masked
    '{K_WR,  2'd0, 12'h18C, 64'hFFFF_F404,    32'd0,   8'd6},  // R6 extra bits dropped
    '{K_RD,  2'd0, 12'h18C, 64'd0,            32'h404, 8'd6},  // R6
    '{K_OUT, 2'd0, 12'h000, 64'd0,            32'h44,  8'd9},  // R9 fiq core2
    '{K_WR,  2'd0, 12'h034, 64'd35,           32'd0,   8'd3},  // R3 disable 35
    '{K_OUT, 2'd0, 12'h000, 64'd0,            32'h00,  8'd3},  // R3
    '{K_RD,  2'd2, 12'h044, 64'd0,            32'd1023, 8'd3}, // R3
    '{K_SRC, 2'd0, 12'h000, 64'h8_0000_0020,  32'd0,   8'd8},  // R8 sources 5 and 35
    '{K_WR,  2'd0, 12'h030, 64'd35,           32'd0,   8'd3},  // R3
    '{K_WR,  2'd0, 12'h030, 64'd5,            32'd0,   8'd3},  // R3
    '{K_WR,  2'd1, 12'h04C, 64'd5,            32'd0,   8'd8},  // R8 private, no route
    '{K_OUT, 2'd0, 12'h000, 64'd0,            32'h46,  8'd8},  // R8
    '{K_RD,  2'd1, 12'h044, 64'd0,            32'd5,   8'd8},  // R8
    '{K_WR,  2'd2, 12'h04C, 64'd5,            32'd0,   8'd10}, // R10
    '{K_RD,  2'd2, 12'h044, 64'd0,            32'd5,   8'd10}, // R10 lowest wins
    '{K_WR,  2'd2, 12'h048, 64'd5,            32'd0,   8'd5},  // R5 mask core2
    '{K_RD,  2'd2, 12'h044, 64'd0,            32'd35,  8'd5},  // R5
    '{K_RD,  2'd1, 12'h044, 64'd0,            32'd5,   8'd5},  // R5 core1 untouched
    '{K_SRC, 2'd0, 12'h000, 64'h1,            32'd0,   8'd4},  // R4 source 0
    '{K_WR,  2'd0, 12'h034, 64'd0,            32'd0,   8'd4},  // R4 ignored clear
    '{K_WR,  2'd3, 12'h04C, 64'd0,            32'd0,   8'd4},  // R4
    '{K_OUT, 2'd0, 12'h000, 64'd0,            32'h08,  8'd4},  // R4 always enabled
    '{K_WR,  2'd0, 12'h100, 64'h0F0F,         32'd0,   8'd6},  // R6 internal word
    '{K_RD,  2'd0, 12'h100, 64'd0,            32'd0,   8'd6},  // R6
    '{K_OUT, 2'd0, 12'h000, 64'd0,            32'h08,  8'd6},  // R6 no fiq appears
    '{K_RD,  2'd0, 12'h050, 64'd0,            32'd0,   8'd2}   // R2 hole reads zero
  };

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        K_WR:  bus_write(VEC[i].addr, VEC[i].data[31:0], VEC[i].core);
        K_SRC: begin
          @(negedge clk);
          src_lvl = VEC[i].data[NSRC-1:0];
        end
        K_RD: begin
          bus_read(VEC[i].addr, VEC[i].core, v);
          check($sformatf("R%0d", VEC[i].req), $sformatf("vector %0d read", i), v, VEC[i].exp);
        end
        default: begin
          out_sample(v);
          check($sformatf("R%0d", VEC[i].req), $sformatf("vector %0d outputs", i), v, VEC[i].exp);
        end
      endcase
    end

    // R11: source rises while its mask is set for core1 in the same cycle
    @(negedge clk);
    src_lvl = 40'h20;
    bus_addr = 12'h048; bus_wdata = 32'd5; bus_core = 2'd1; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R11", "one-cycle pulse from old mask", {24'd0, core_fiq, core_irq}, 32'h02);
    out_sample(v);
    check("R11", "pulse gone after mask", v, 32'h00);

    // R11: read and write of one routing word in the same cycle
    @(negedge clk);
    bus_addr = 12'h18C; bus_wdata = 32'h2; bus_core = 2'd0; bus_wr = 1'b1; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R11", "read shows pre-write word", bus_rdata, 32'h404);
    bus_read(12'h18C, 2'd0, v);
    check("R11", "next read shows new word", v, 32'h002);

    // R7: highest source number
    @(negedge clk);
    src_lvl = 40'h80_0000_0000;
    bus_write(12'h030, 32'd39, 2'd0);
    bus_write(12'h04C, 32'd39, 2'd0);
    bus_write(12'h19C, 32'h1, 2'd0);
    bus_read(12'h044, 2'd0, v);
    check("R7", "ack of last source", v, 32'd39);
    out_sample(v);
    check("R7", "irq core0 from last source", v, 32'h01);

    // R1: reset in mid-run clears all state
    @(negedge clk);
    rst_n = 1'b0;
    src_lvl = '1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    out_sample(v);
    check("R1", "outputs after reset", v, 32'h00);
    bus_read(12'h19C, 2'd0, v);
    check("R1", "route after reset", v, 32'd0);
    bus_read(12'h044, 2'd1, v);
    check("R1", "ack after reset", v, 32'd1023);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule